// File: doc/BRIEF.md
# NAND Read-Retry Parameter Sequencer

This block sits on the controller side of a raw NAND flash interface and turns a single start request into the vendor-specific cycles that change the flash's read thresholds. It emits a stream of abstract cycle requests, one at a time, on a valid/ready channel. Each request is a command byte, an address byte, a data byte written to the flash, a data byte read from the flash, or a wait for the flash's ready indication. A downstream pin driver turns these requests into electrical NAND cycles.

Two operations are offered. "Apply mode" programs one read-retry mode. It writes the value group that belongs to the chosen mode into a list of internal flash registers, and brackets those writes with an enter opcode and a commit opcode. "OTP read" resets the flash and unlocks the one-time-programmable area. It reads that area as a page using one of two layouts, then resets the flash and restores normal operation. The register addresses and the per-mode values live in two small internal tables, which are loaded through a write port. The register count and the mode count are run-time inputs.

A cycle that stays unaccepted for too long aborts the operation with an error pulse. A completed operation gives a done pulse. A busy output covers the whole operation.

Top module: `nrr_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `done_o`, `err_o` and `cyc_valid_o` are all 0.
- R2: Apply mode (`op_i`=0) emits, in order: a command 0x36; then for each register i from 0 to `nregs_i`-1 an address cycle, a second address cycle and one data-in cycle; then a command 0x16. Kind codes on `cyc_kind_o`: 0 command, 1 address, 2 data-in (byte to flash), 3 data-out (byte from flash), 4 wait-ready.
- R3: In apply mode both address bytes of register i equal register-table entry i. The data byte equals value-table entry `mode_i`*`nregs_i`+i.
- R4: The register count is taken at run time. With `nregs_i`=0, apply mode emits only the 0x36 and 0x16 commands.
- R5: OTP read (`op_i`=1) begins with a reset (command 0xFF, then wait-ready). It then sends 0x36, address 0x38 twice, data 0x52, and 0x16, followed by commands 0x17, 0x04 and 0x19. Next comes a page read: command 0x00, two column address bytes of 0x00, three row bytes (least significant first), command 0x30, wait-ready, then one data-out cycle per byte.
- R6: `otp_sel_i`=0 selects row 0x00021F with 784 data-out cycles. `otp_sel_i`=1 selects row 0x000200 with 528.
- R7: After the OTP page read the sequence ends with: a reset (0xFF, wait-ready); 0x36; address 0x38 twice; data 0x00; 0x16; and a page read of row 0 with no data-out cycles.
- R8: While `cyc_valid_o` is high and `cyc_ready_i` low, the request holds its kind and byte unchanged into the next cycle.
- R9: If one request stays unaccepted for more than `tmo_limit_i` clock edges, the operation aborts. `err_o` pulses for one cycle, `busy_o` falls in that same cycle, and no done pulse follows.
- R10: On success `done_o` pulses for exactly one cycle, and `busy_o` is already low in that cycle.
- R11: A start request while `busy_o` is high is ignored: the running operation's cycle stream and its single done pulse are unchanged.
- R12: An apply request whose mode is at least `nmodes_i`, whose `nregs_i` exceeds the register-table depth, or whose value group runs past the value-table end produces one `err_o` pulse. It emits no cycle and never raises `busy_o`.
- R13: With `tbl_we_i` high, `tbl_data_i` is written at `tbl_addr_i` into the register table (`tbl_sel_i`=0) or the value table (`tbl_sel_i`=1). Later apply operations use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| op_i | input | 1 | 0 apply mode, 1 OTP read |
| mode_i | input | MODE_W | Read-retry mode index |
| nmodes_i | input | MODE_W+1 | Number of valid modes |
| nregs_i | input | NR_W | Number of registers per mode |
| otp_sel_i | input | 1 | OTP layout select |
| tmo_limit_i | input | TMO_W | Acceptance timeout in cycles |
| tbl_we_i | input | 1 | Table write enable |
| tbl_sel_i | input | 1 | 0 register table, 1 value table |
| tbl_addr_i | input | VA_W | Table write address |
| tbl_data_i | input | 8 | Table write data |
| cyc_valid_o | output | 1 | Cycle request valid |
| cyc_ready_i | input | 1 | Cycle request accepted / flash ready |
| cyc_kind_o | output | 3 | Cycle kind code |
| cyc_byte_o | output | 8 | Command, address or data byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle error pulse |

## Verification
The bench targets the last mode whose value group ends exactly at the top of the value table. A design with a wrong base offset would there read past the table or pick a neighbouring mode's values. It also runs a zero register count, where a design that enters the register loop anyway would emit a stray address pair. Both OTP layouts are covered, to catch a swapped row or length, and the trailing dummy page read, which must carry no data-out cycles. Random ready stalls show whether a design advances on valid alone. A stuck ready, a start issued mid-run and an out-of-range mode expose designs that hang, restart, or emit cycles for a request they should reject.

// File: rtl/nrr_pkg.sv
// Package: shared types and the step program for the read-retry sequencer.
// Assumes: each operation is at most 16 macro steps long.
package nrr_pkg;

    // Cycle kind codes seen on the request channel
    typedef enum logic [2:0] {
        CK_CMD  = 3'd0,
        CK_ADDR = 3'd1,
        CK_DIN  = 3'd2,
        CK_DOUT = 3'd3,
        CK_WAIT = 3'd4
    } cyc_kind_e;

    // Macro step kinds; each expands into one or more cycles
    typedef enum logic [2:0] {
        MK_CMD,
        MK_REGFIX,
        MK_REGTBL,
        MK_RESET,
        MK_PAGE,
        MK_DONE
    } mac_kind_e;

    typedef struct packed {
        mac_kind_e   kind;
        logic [7:0]  a;       // command byte or register address
        logic [7:0]  b;       // register value for fixed writes
        logic        otp_pg;  // page read targets the OTP layout
    } mac_t;

    localparam logic [7:0] OPC_ENTER  = 8'h36;
    localparam logic [7:0] OPC_COMMIT = 8'h16;
    localparam logic [7:0] OPC_RESET  = 8'hFF;
    localparam logic [7:0] OPC_RD1    = 8'h00;
    localparam logic [7:0] OPC_RD2    = 8'h30;
    localparam logic [7:0] OPC_OTP_A  = 8'h17;
    localparam logic [7:0] OPC_OTP_B  = 8'h04;
    localparam logic [7:0] OPC_OTP_C  = 8'h19;
    localparam logic [7:0] OTP_REG    = 8'h38;
    localparam logic [7:0] OTP_UNLOCK = 8'h52;
    localparam logic [7:0] OTP_LOCK   = 8'h00;

    // Returns the macro step at index stp for the selected operation
    function automatic mac_t prog_step(input logic is_otp, input logic [3:0] stp);
        mac_t m;
        m = '{kind: MK_DONE, a: 8'h00, b: 8'h00, otp_pg: 1'b0};
        if (!is_otp) begin
            case (stp)
                4'd0: m = '{kind: MK_CMD,    a: OPC_ENTER,  b: 8'h00, otp_pg: 1'b0};
                4'd1: m = '{kind: MK_REGTBL, a: 8'h00,      b: 8'h00, otp_pg: 1'b0};
                4'd2: m = '{kind: MK_CMD,    a: OPC_COMMIT, b: 8'h00, otp_pg: 1'b0};
                default: ;
            endcase
        end else begin
            case (stp)
                4'd0:  m = '{kind: MK_RESET,  a: 8'h00,      b: 8'h00,       otp_pg: 1'b0};
                4'd1:  m = '{kind: MK_CMD,    a: OPC_ENTER,  b: 8'h00,       otp_pg: 1'b0};
                4'd2:  m = '{kind: MK_REGFIX, a: OTP_REG,    b: OTP_UNLOCK,  otp_pg: 1'b0};
                4'd3:  m = '{kind: MK_CMD,    a: OPC_COMMIT, b: 8'h00,       otp_pg: 1'b0};
                4'd4:  m = '{kind: MK_CMD,    a: OPC_OTP_A,  b: 8'h00,       otp_pg: 1'b0};
                4'd5:  m = '{kind: MK_CMD,    a: OPC_OTP_B,  b: 8'h00,       otp_pg: 1'b0};
                4'd6:  m = '{kind: MK_CMD,    a: OPC_OTP_C,  b: 8'h00,       otp_pg: 1'b0};
                4'd7:  m = '{kind: MK_PAGE,   a: 8'h00,      b: 8'h00,       otp_pg: 1'b1};
                4'd8:  m = '{kind: MK_RESET,  a: 8'h00,      b: 8'h00,       otp_pg: 1'b0};
                4'd9:  m = '{kind: MK_CMD,    a: OPC_ENTER,  b: 8'h00,       otp_pg: 1'b0};
                4'd10: m = '{kind: MK_REGFIX, a: OTP_REG,    b: OTP_LOCK,    otp_pg: 1'b0};
                4'd11: m = '{kind: MK_CMD,    a: OPC_COMMIT, b: 8'h00,       otp_pg: 1'b0};
                4'd12: m = '{kind: MK_PAGE,   a: 8'h00,      b: 8'h00,       otp_pg: 1'b0};
                default: ;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/nrr_tbl.sv
// Module: small byte table with one synchronous write port and one
// combinational read port.
// Assumes: DEPTH is small enough for flops; reads of unwritten entries return 0.
module nrr_tbl #(
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Clear on reset, then store one byte per write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read for the current register index
    assign rdata = mem[raddr];
endmodule

// File: rtl/nrr_tmo.sv
// Module: acceptance timeout for one pending request.
// Assumes: the count restarts whenever the request is accepted or withdrawn.
module nrr_tmo #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pend,
    input  logic         hit,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Count edges a request waits without acceptance, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (!pend || hit)  cnt <= '0;
        else if (cnt != limit)  cnt <= cnt + 1'b1;
    end

    // Flag expiry when the wait has reached the limit and still no acceptance
    assign expired = pend && !hit && (cnt == limit);

    // R9: the wait count never passes a limit that is held steady
    assert_cnt_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && $stable(limit) && cnt <= limit) |=> (cnt <= limit));
endmodule

// File: rtl/nrr_cycgen.sv
// Module: expands the current macro step and its sub-cycle index into one
// cycle request, and reports when the step ends.
// Assumes: purely combinational; the caller owns all step and index state.
module nrr_cycgen
    import nrr_pkg::*;
#(
    parameter int SUB_W = 10,
    parameter int LEN_W = 10
) (
    input  mac_t             mac,
    input  logic [SUB_W-1:0] sub,
    input  logic             reg_last,
    input  logic             nregs_zero,
    input  logic [7:0]       reg_byte,
    input  logic [7:0]       val_byte,
    input  logic [23:0]      row,
    input  logic [LEN_W-1:0] len,
    output logic             req_valid,
    output cyc_kind_e        req_kind,
    output logic [7:0]       req_byte,
    output logic             req_last,
    output logic             req_skip,
    output logic             reg_wrap
);
    logic [SUB_W-1:0] page_end;

    // Last sub-cycle of a page read: the wait, or the final data-out byte
    assign page_end = SUB_W'(7) + SUB_W'(len);

    // Decode the request for this macro step and sub-cycle
    always_comb begin
        req_valid = 1'b1;
        req_kind  = CK_CMD;
        req_byte  = 8'h00;
        req_last  = 1'b0;
        req_skip  = 1'b0;
        reg_wrap  = 1'b0;
        case (mac.kind)
            MK_CMD: begin
                req_byte = mac.a;
                req_last = 1'b1;
            end
            MK_REGFIX: begin
                req_kind = (sub == SUB_W'(2)) ? CK_DIN : CK_ADDR;
                req_byte = (sub == SUB_W'(2)) ? mac.b : mac.a;
                req_last = (sub == SUB_W'(2));
            end
            MK_REGTBL: begin
                if (nregs_zero) begin
                    req_valid = 1'b0;
                    req_skip  = 1'b1;
                end else begin
                    req_kind = (sub == SUB_W'(2)) ? CK_DIN : CK_ADDR;
                    req_byte = (sub == SUB_W'(2)) ? val_byte : reg_byte;
                    reg_wrap = (sub == SUB_W'(2));
                    req_last = (sub == SUB_W'(2)) && reg_last;
                end
            end
            MK_RESET: begin
                req_kind = (sub == SUB_W'(0)) ? CK_CMD : CK_WAIT;
                req_byte = (sub == SUB_W'(0)) ? OPC_RESET : 8'h00;
                req_last = (sub == SUB_W'(1));
            end
            MK_PAGE: begin
                req_last = (sub == page_end);
                if (sub == SUB_W'(0)) begin
                    req_byte = OPC_RD1;
                end else if (sub <= SUB_W'(2)) begin
                    req_kind = CK_ADDR;
                end else if (sub == SUB_W'(3)) begin
                    req_kind = CK_ADDR;
                    req_byte = row[7:0];
                end else if (sub == SUB_W'(4)) begin
                    req_kind = CK_ADDR;
                    req_byte = row[15:8];
                end else if (sub == SUB_W'(5)) begin
                    req_kind = CK_ADDR;
                    req_byte = row[23:16];
                end else if (sub == SUB_W'(6)) begin
                    req_byte = OPC_RD2;
                end else if (sub == SUB_W'(7)) begin
                    req_kind = CK_WAIT;
                end else begin
                    req_kind = CK_DOUT;
                end
            end
            default: begin
                req_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/nrr_seq.sv
// Module: read-retry parameter sequencer top. Accepts a start request,
// walks the macro program of the chosen operation and issues one cycle
// request at a time on a valid/ready channel.
// Assumes: one operation at a time; the downstream driver raises ready on a
// wait-ready request only once the flash reports ready.
module nrr_seq
    import nrr_pkg::*;
#(
    parameter int          REG_DEPTH = 8,
    parameter int          VAL_DEPTH = 64,
    parameter int          MODE_W    = 4,
    parameter int          TMO_W     = 16,
    parameter logic [23:0] OTP_PAGE0 = 24'h00021F,
    parameter int          OTP_LEN0  = 784,
    parameter logic [23:0] OTP_PAGE1 = 24'h000200,
    parameter int          OTP_LEN1  = 528,
    localparam int RA_W    = $clog2(REG_DEPTH),
    localparam int VA_W    = $clog2(VAL_DEPTH),
    localparam int NR_W    = $clog2(REG_DEPTH + 1),
    localparam int LEN_MAX = (OTP_LEN0 > OTP_LEN1) ? OTP_LEN0 : OTP_LEN1,
    localparam int LEN_W   = $clog2(LEN_MAX + 1),
    localparam int SUB_W   = $clog2(LEN_MAX + 9),
    localparam int PW      = MODE_W + NR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [MODE_W:0]   nmodes_i,
    input  logic [NR_W-1:0]   nregs_i,
    input  logic              otp_sel_i,
    input  logic [TMO_W-1:0]  tmo_limit_i,
    input  logic              tbl_we_i,
    input  logic              tbl_sel_i,
    input  logic [VA_W-1:0]   tbl_addr_i,
    input  logic [7:0]        tbl_data_i,
    output logic              cyc_valid_o,
    input  logic              cyc_ready_i,
    output logic [2:0]        cyc_kind_o,
    output logic [7:0]        cyc_byte_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    logic             active, op_q, sel_q, done_q, err_q;
    logic [3:0]       stp;
    logic [SUB_W-1:0] sub;
    logic [RA_W-1:0]  ri;
    logic [VA_W-1:0]  base_q;
    logic [NR_W-1:0]  nregs_q;
    mac_t             mac;
    logic [7:0]       reg_byte, val_byte;
    logic [23:0]      cur_row;
    logic [LEN_W-1:0] cur_len;
    logic             req_valid, req_last, req_skip, reg_wrap, reg_last, tmo_exp;
    cyc_kind_e        req_kind;
    logic [7:0]       req_byte;
    logic [PW-1:0]    grp_end, grp_base;
    logic             bad_req;

    // Value group bounds for the requested mode
    assign grp_base = PW'(mode_i) * PW'(nregs_i);
    assign grp_end  = grp_base + PW'(nregs_i);
    assign bad_req  = ({1'b0, mode_i} >= nmodes_i) ||
                      (nregs_i > NR_W'(REG_DEPTH)) ||
                      (grp_end > PW'(VAL_DEPTH));

    // Table write decode: register table takes only in-range addresses
    logic reg_we, val_we;
    assign reg_we = tbl_we_i && !tbl_sel_i && (int'(tbl_addr_i) < REG_DEPTH);
    assign val_we = tbl_we_i &&  tbl_sel_i;

    nrr_tbl #(.DEPTH(REG_DEPTH), .AW(RA_W)) u_regtbl (
        .clk(clk), .rst_n(rst_n), .we(reg_we),
        .waddr(tbl_addr_i[RA_W-1:0]), .wdata(tbl_data_i),
        .raddr(ri), .rdata(reg_byte)
    );

    nrr_tbl #(.DEPTH(VAL_DEPTH), .AW(VA_W)) u_valtbl (
        .clk(clk), .rst_n(rst_n), .we(val_we),
        .waddr(tbl_addr_i), .wdata(tbl_data_i),
        .raddr(base_q + VA_W'(ri)), .rdata(val_byte)
    );

    // Current macro step and the page parameters it needs
    assign mac      = prog_step(op_q, stp);
    assign cur_row  = !mac.otp_pg ? 24'h000000 : (sel_q ? OTP_PAGE1 : OTP_PAGE0);
    assign cur_len  = !mac.otp_pg ? '0 : (sel_q ? LEN_W'(OTP_LEN1) : LEN_W'(OTP_LEN0));
    assign reg_last = (NR_W'(ri) == nregs_q - NR_W'(1));

    nrr_cycgen #(.SUB_W(SUB_W), .LEN_W(LEN_W)) u_cycgen (
        .mac(mac), .sub(sub), .reg_last(reg_last),
        .nregs_zero(nregs_q == '0), .reg_byte(reg_byte), .val_byte(val_byte),
        .row(cur_row), .len(cur_len),
        .req_valid(req_valid), .req_kind(req_kind), .req_byte(req_byte),
        .req_last(req_last), .req_skip(req_skip), .reg_wrap(reg_wrap)
    );

    nrr_tmo #(.W(TMO_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .pend(cyc_valid_o), .hit(cyc_ready_i),
        .limit(tmo_limit_i), .expired(tmo_exp)
    );

    // Operation control: start, step advance, completion and abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            op_q    <= 1'b0;
            sel_q   <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            stp     <= '0;
            sub     <= '0;
            ri      <= '0;
            base_q  <= '0;
            nregs_q <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (!active) begin
                if (start_i) begin
                    if (!op_i && bad_req) begin
                        err_q <= 1'b1;
                    end else begin
                        active  <= 1'b1;
                        op_q    <= op_i;
                        sel_q   <= otp_sel_i;
                        stp     <= '0;
                        sub     <= '0;
                        ri      <= '0;
                        base_q  <= grp_base[VA_W-1:0];
                        nregs_q <= nregs_i;
                    end
                end
            end else if (tmo_exp) begin
                active <= 1'b0;
                err_q  <= 1'b1;
            end else if (mac.kind == MK_DONE) begin
                active <= 1'b0;
                done_q <= 1'b1;
            end else if (req_skip) begin
                stp <= stp + 4'd1;
            end else if (cyc_valid_o && cyc_ready_i) begin
                if (req_last) begin
                    stp <= stp + 4'd1;
                    sub <= '0;
                    ri  <= '0;
                end else if (reg_wrap) begin
                    sub <= '0;
                    ri  <= ri + 1'b1;
                end else begin
                    sub <= sub + 1'b1;
                end
            end
        end
    end

    assign cyc_valid_o = active && req_valid;
    assign cyc_kind_o  = req_kind;
    assign cyc_byte_o  = req_byte;
    assign busy_o      = active;
    assign done_o      = done_q;
    assign err_o       = err_q;

    // R8: an unaccepted request holds its content into the next cycle
    assert_req_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid_o && !cyc_ready_i && !tmo_exp) |=>
        (cyc_valid_o && $stable(cyc_kind_o) && $stable(cyc_byte_o)));

    // R10: done is raised only once busy has fallen
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R9: success and error never pulse together
    assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, err_o}));

    // R1: requests appear only inside an operation
    assert_valid_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid_o |-> busy_o);

    // R11: busy rises only from a start seen while idle
    assert_start_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R12: an error pulse never coexists with a running operation
    assert_err_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o);
endmodule

// File: tb/tb_nrr_seq.sv
module tb_nrr_seq;
    localparam int KC = 0, KA = 1, KI = 2, KO = 3, KW = 4;
    localparam int LOGN = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, op_i = 1'b0, otp_sel_i = 1'b0;
    logic [3:0] mode_i = '0;
    logic [4:0] nmodes_i = 5'd8;
    logic [3:0] nregs_i = '0;
    logic [15:0] tmo_limit_i = 16'd1000;
    logic       tbl_we_i = 1'b0, tbl_sel_i = 1'b0;
    logic [5:0] tbl_addr_i = '0;
    logic [7:0] tbl_data_i = '0;
    logic       cyc_valid_o, cyc_ready_i = 1'b0;
    logic [2:0] cyc_kind_o;
    logic [7:0] cyc_byte_o;
    logic       busy_o, done_o, err_o;

    nrr_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .mode_i(mode_i), .nmodes_i(nmodes_i), .nregs_i(nregs_i),
        .otp_sel_i(otp_sel_i), .tmo_limit_i(tmo_limit_i),
        .tbl_we_i(tbl_we_i), .tbl_sel_i(tbl_sel_i), .tbl_addr_i(tbl_addr_i),
        .tbl_data_i(tbl_data_i), .cyc_valid_o(cyc_valid_o),
        .cyc_ready_i(cyc_ready_i), .cyc_kind_o(cyc_kind_o),
        .cyc_byte_o(cyc_byte_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    always #2.5 clk = ~clk;

    int n_tests = 0, n_fail = 0;
    int cyc_n = 0, done_cnt = 0, err_cnt = 0;
    int log_n = 0, exp_n = 0;
    logic [10:0] log_kb [LOGN];
    logic [10:0] exp_kb [LOGN];
    logic [7:0]  regtab [8];
    logic [7:0]  valtab [64];
    logic [7:0]  lfsr = 8'h5A;
    bit stall_en = 0, block_rdy = 0, overlap_bad = 0;

    // op, sel, stall, mode, nregs
    localparam logic [15:0] VEC [7] = '{
        16'h0008, 16'h2308, 16'h0708, 16'h0503,
        16'h0200, 16'h8000, 16'hE000
    };

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Responder: ready policy, acceptance log, pulse counters, watchdog
    always @(negedge clk) begin
        logic rdy;
        cyc_n++;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rdy = block_rdy ? 1'b0 : (stall_en ? (lfsr[0] | lfsr[2]) : 1'b1);
        cyc_ready_i = rdy;
        if (cyc_valid_o && rdy && log_n < LOGN) begin
            log_kb[log_n] = {cyc_kind_o, cyc_byte_o};
            log_n++;
        end
        if (done_o) begin
            done_cnt++;
            if (busy_o) overlap_bad = 1;
        end
        if (err_o) err_cnt++;
        if (cyc_n > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_n, 150000);
            finish_run();
        end
    end

    task automatic push(input int k, input logic [7:0] b);
        exp_kb[exp_n] = {3'(k), b};
        exp_n++;
    endtask

    task automatic exp_apply(input int mode, input int nr);
        exp_n = 0;
        push(KC, 8'h36);
        for (int i = 0; i < nr; i++) begin
            push(KA, regtab[i]); push(KA, regtab[i]); push(KI, valtab[mode * nr + i]);
        end
        push(KC, 8'h16);
    endtask

    task automatic exp_page(input logic [23:0] row, input int len);
        push(KC, 8'h00); push(KA, 8'h00); push(KA, 8'h00);
        push(KA, row[7:0]); push(KA, row[15:8]); push(KA, row[23:16]);
        push(KC, 8'h30); push(KW, 8'h00);
        for (int i = 0; i < len; i++) push(KO, 8'h00);
    endtask

    task automatic exp_otp(input bit sel);
        exp_n = 0;
        push(KC, 8'hFF); push(KW, 8'h00); push(KC, 8'h36);
        push(KA, 8'h38); push(KA, 8'h38); push(KI, 8'h52); push(KC, 8'h16);
        push(KC, 8'h17); push(KC, 8'h04); push(KC, 8'h19);
        exp_page(sel ? 24'h000200 : 24'h00021F, sel ? 528 : 784);
        push(KC, 8'hFF); push(KW, 8'h00); push(KC, 8'h36);
        push(KA, 8'h38); push(KA, 8'h38); push(KI, 8'h00); push(KC, 8'h16);
        exp_page(24'h000000, 0);
    endtask

    task automatic compare_log(input string tag);
        int bad = -1;
        check(log_n == exp_n, {tag, " length"}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (bad < 0 && log_kb[i] !== exp_kb[i]) bad = i;
        if (bad >= 0)
            check(0, {tag, " content"}, int'(log_kb[bad]), int'(exp_kb[bad]));
        else
            check(1, {tag, " content"}, 0, 0);
    endtask

    task automatic tbl_wr(input bit sel, input int addr, input logic [7:0] d);
        @(negedge clk); #1;
        tbl_we_i = 1; tbl_sel_i = sel; tbl_addr_i = 6'(addr); tbl_data_i = d;
        if (sel) valtab[addr] = d; else regtab[addr] = d;
        @(negedge clk); #1;
        tbl_we_i = 0;
    endtask

    task automatic launch(input bit op, input bit sel, input int mode, input int nr);
        @(negedge clk); #1;
        op_i = op; otp_sel_i = sel; mode_i = 4'(mode); nregs_i = 4'(nr);
        log_n = 0; overlap_bad = 0;
        start_i = 1;
        @(negedge clk); #1;
        start_i = 0;
    endtask

    task automatic wait_end(input int dc0, input int ec0);
        for (int k = 0; k < 20000; k++) begin
            if (done_cnt != dc0 || err_cnt != ec0) break;
            @(negedge clk); #1;
        end
        repeat (4) @(negedge clk);
        #1;
    endtask

    initial begin
        int dc0, ec0;
        // Reset and R1
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        check(!busy_o && !done_o && !err_o && !cyc_valid_o, "R1 idle after reset",
              {busy_o, done_o, err_o, cyc_valid_o}, 0);

        // Load tables through the write port (R13)
        for (int i = 0; i < 8; i++) tbl_wr(0, i, 8'hA0 + 8'(i * 5));
        for (int i = 0; i < 64; i++) tbl_wr(1, i, 8'(i * 37 + 11));

        // Vector table walk: R2 R3 R4 R5 R6 R7 R8 R10 R13
        for (int v = 0; v < 7; v++) begin
            bit op, sel, st;
            int md, nr;
            string tag;
            op = VEC[v][15]; sel = VEC[v][14]; st = VEC[v][13];
            md = int'(VEC[v][11:8]); nr = int'(VEC[v][3:0]);
            if (op) begin exp_otp(sel); tag = $sformatf("R5 R6 R7 R8 vec%0d", v); end
            else begin exp_apply(md, nr); tag = $sformatf("R2 R3 R4 R8 R13 vec%0d", v); end
            stall_en = st;
            dc0 = done_cnt; ec0 = err_cnt;
            launch(op, sel, md, nr);
            wait_end(dc0, ec0);
            stall_en = 0;
            compare_log(tag);
            check(done_cnt - dc0 == 1 && err_cnt == ec0 && !overlap_bad && !busy_o,
                  "R10 single done pulse", done_cnt - dc0, 1);
        end

        // R13: rewrite one value entry and see it used
        tbl_wr(1, 6, 8'h5C);
        exp_apply(1, 4);
        dc0 = done_cnt; ec0 = err_cnt;
        launch(0, 0, 1, 4);
        wait_end(dc0, ec0);
        compare_log("R13 rewritten value");

        // R11: second start during a run is ignored
        exp_apply(0, 8);
        dc0 = done_cnt; ec0 = err_cnt;
        launch(0, 0, 0, 8);
        @(negedge clk); #1;
        op_i = 1; start_i = 1;
        @(negedge clk); #1;
        start_i = 0; op_i = 0;
        wait_end(dc0, ec0);
        repeat (20) @(negedge clk);
        #1;
        compare_log("R11 start while busy");
        check(done_cnt - dc0 == 1, "R11 one done", done_cnt - dc0, 1);

        // R12: out-of-range mode and overrun group
        dc0 = done_cnt; ec0 = err_cnt;
        launch(0, 0, 8, 8);
        wait_end(dc0, ec0);
        check(err_cnt - ec0 == 1 && log_n == 0 && done_cnt == dc0,
              "R12 mode beyond count", log_n, 0);
        nmodes_i = 5'd16;
        dc0 = done_cnt; ec0 = err_cnt;
        launch(0, 0, 8, 8);
        wait_end(dc0, ec0);
        check(err_cnt - ec0 == 1 && log_n == 0, "R12 group past table end", err_cnt - ec0, 1);
        nmodes_i = 5'd8;

        // R9: stuck ready aborts with error and no done
        tmo_limit_i = 16'd5;
        block_rdy = 1;
        dc0 = done_cnt; ec0 = err_cnt;
        launch(0, 0, 2, 4);
        wait_end(dc0, ec0);
        check(err_cnt - ec0 == 1 && done_cnt == dc0, "R9 timeout error", err_cnt - ec0, 1);
        check(!busy_o && !cyc_valid_o && log_n == 0, "R9 idle after abort", busy_o, 0);
        block_rdy = 0;
        tmo_limit_i = 16'd1000;

        // R9: operation works again after an abort
        exp_apply(2, 4);
        dc0 = done_cnt; ec0 = err_cnt;
        launch(0, 0, 2, 4);
        wait_end(dc0, ec0);
        compare_log("R9 recovery run");

        finish_run();
    end
endmodule